// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block decides which of two reference inputs feeds a downstream tracking loop. Its inputs are a per-reference valid flag from a loss-of-signal monitor, a priority bit that marks one reference as preferred, a mode bit (automatic or manual), a revertive enable and a manual choice pin. It reports the chosen reference index, a holdover request when nothing usable is present, a one-cycle switch pulse, and a one-cycle pulse whenever any valid flag changes. It does not align phase. It only makes the choice and flags the transitions.

The controller is a three-state machine with the states `ST_HOLD`, `ST_REF0` and `ST_REF1`. Every transition comes from the valid flags and configuration sampled on the same clock edge, so a decision appears on the outputs one clock after its cause.

- **Hold to track.** In automatic mode, the machine leaves `ST_HOLD` for the preferred valid reference. If the preferred one is invalid, it goes to the other valid reference. In manual mode, it leaves `ST_HOLD` for the manually chosen reference once that reference is valid.
- **Track to hold.** In automatic mode, this happens when no reference is valid. In manual mode, it happens when the chosen reference is invalid.
- **Failover.** The machine moves from one track state to the other when the current reference fails and the other is valid.
- **Revert.** With revertive enable set, the machine moves from one track state to the other when the preferred reference becomes valid again.
- **Manual change.** A change of the manual pin moves the machine to the newly chosen reference while that reference is valid.

Top module: `ref_clk_selector`

## Requirements
- R1: While reset is held, `holdover` is 1, `sel_idx` is 0, and `switch_pulse` and `status_chg` are 0.
- R2: In automatic mode, `prio_sel`=0 makes reference 0 preferred and `prio_sel`=1 makes reference 1 preferred. From holdover, the preferred valid reference (or else the other valid one) is selected on the first clock edge at which its valid flag is sampled high.
- R3: In automatic mode, when the selected reference's valid flag drops and the other reference is valid, `sel_idx` moves to the other reference one clock later.
- R4: In automatic mode, when both valid flags are low, `holdover` becomes 1 one clock later.
- R5: In automatic mode with `revert_en`=1, when the non-preferred reference is selected and the preferred reference is valid, `sel_idx` moves to the preferred reference one clock later.
- R6: In automatic mode with `revert_en`=0, the block keeps the selected reference for as long as it stays valid, even when the preferred reference is valid.
- R7: In manual mode (`auto_mode`=0), `sel_idx` equals `man_sel` (0 = reference 0, 1 = reference 1) one clock after that reference is sampled valid.
- R8: In manual mode, when the reference chosen by `man_sel` is invalid, `holdover` becomes 1 and the other reference is not selected, even if it is valid.
- R9: `switch_pulse` is high for exactly one cycle in the cycle where `sel_idx` changes or `holdover` changes, and is low in all other cycles.
- R10: `status_chg` is high for one cycle, one clock after any bit of `ref_valid` changes value. The flags are taken as 0 during reset.
- R11: During holdover, `sel_idx` keeps the index of the last selected reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decision clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 2 | Per-reference valid flags from the signal monitor; bit i belongs to reference i |
| auto_mode | input | 1 | 1 = automatic selection, 0 = manual selection |
| revert_en | input | 1 | 1 = revertive automatic selection |
| prio_sel | input | 1 | Index of the preferred reference |
| man_sel | input | 1 | Reference chosen in manual mode |
| sel_idx | output | 1 | Index of the selected (or last selected) reference |
| holdover | output | 1 | Holdover request, high when no applicable reference is valid |
| switch_pulse | output | 1 | One-cycle pulse on a change of selection or holdover |
| status_chg | output | 1 | One-cycle pulse after any valid flag changes |

## Verification
The properties assume that the valid flags and configuration pins are synchronous to `clk` and stable around each rising edge. They also assume that each output cycle reflects the inputs captured at the edge before it. The checker therefore compares each output against its own registered copy of the previous cycle's inputs, and it only starts doing so after one clock out of reset. The bench changes inputs only on falling edges and samples outputs one time unit after each rising edge, which keeps every stimulus inside that assumption.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int N_REF = 2;
    localparam int IDX_W = (N_REF > 1) ? $clog2(N_REF) : 1;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_REF0 = 2'd1,
        ST_REF1 = 2'd2
    } sel_state_e;

    function automatic sel_state_e idx_to_state(input logic [IDX_W-1:0] idx);
        return (idx == '0) ? ST_REF0 : ST_REF1;
    endfunction
endpackage

// File: rtl/rcs_prio_pick.sv
module rcs_prio_pick
    import rcs_pkg::*;
(
    input  logic [N_REF-1:0] valid,
    input  logic [IDX_W-1:0] prio_sel,
    output logic             any_valid,
    output logic [IDX_W-1:0] best_idx
);
    logic [IDX_W-1:0] other_idx;

    assign other_idx = ~prio_sel;
    assign any_valid = |valid;

    always_comb begin
        if (valid[prio_sel]) begin
            best_idx = prio_sel;
        end else begin
            best_idx = other_idx;
        end
    end
endmodule

// File: rtl/rcs_edge_det.sv
module rcs_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic             changed
);
    logic [WIDTH-1:0] din_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q   <= '0;
            changed <= 1'b0;
        end else begin
            din_q   <= din;
            changed <= (din != din_q);
        end
    end
endmodule

// File: rtl/rcs_fsm.sv
module rcs_fsm
    import rcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REF-1:0] valid,
    input  logic             auto_mode,
    input  logic             revert_en,
    input  logic [IDX_W-1:0] prio_sel,
    input  logic [IDX_W-1:0] man_sel,
    input  logic             any_valid,
    input  logic [IDX_W-1:0] best_idx,
    output logic [IDX_W-1:0] sel_idx,
    output logic             holdover,
    output logic             switch_pulse
);
    sel_state_e       state_q;
    sel_state_e       state_d;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] cur_idx;

    assign cur_idx = (state_q == ST_REF1) ? IDX_W'(1) : IDX_W'(0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (auto_mode) begin
                    if (any_valid) begin
                        state_d = idx_to_state(best_idx);
                    end
                end else if (valid[man_sel]) begin
                    state_d = idx_to_state(man_sel);
                end
            end
            ST_REF0, ST_REF1: begin
                if (!auto_mode) begin
                    state_d = valid[man_sel] ? idx_to_state(man_sel) : ST_HOLD;
                end else if (!valid[cur_idx]) begin
                    state_d = any_valid ? idx_to_state(best_idx) : ST_HOLD;
                end else if (revert_en && (cur_idx != prio_sel)) begin
                    state_d = idx_to_state(best_idx);
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q       <= '0;
            switch_pulse <= 1'b0;
        end else begin
            switch_pulse <= (state_d != state_q);
            if (state_d != ST_HOLD) begin
                last_q <= (state_d == ST_REF1) ? IDX_W'(1) : IDX_W'(0);
            end
        end
    end

    assign holdover = (state_q == ST_HOLD);
    assign sel_idx  = holdover ? last_q : cur_idx;
endmodule

// File: rtl/ref_clk_selector.sv
module ref_clk_selector
    import rcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REF-1:0] ref_valid,
    input  logic             auto_mode,
    input  logic             revert_en,
    input  logic [IDX_W-1:0] prio_sel,
    input  logic [IDX_W-1:0] man_sel,
    output logic [IDX_W-1:0] sel_idx,
    output logic             holdover,
    output logic             switch_pulse,
    output logic             status_chg
);
    logic             any_valid;
    logic [IDX_W-1:0] best_idx;

    rcs_prio_pick i_pick (
        .valid     (ref_valid),
        .prio_sel  (prio_sel),
        .any_valid (any_valid),
        .best_idx  (best_idx)
    );

    rcs_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid        (ref_valid),
        .auto_mode    (auto_mode),
        .revert_en    (revert_en),
        .prio_sel     (prio_sel),
        .man_sel      (man_sel),
        .any_valid    (any_valid),
        .best_idx     (best_idx),
        .sel_idx      (sel_idx),
        .holdover     (holdover),
        .switch_pulse (switch_pulse)
    );

    rcs_edge_det #(.WIDTH(N_REF)) i_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (ref_valid),
        .changed (status_chg)
    );
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker
    import rcs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [N_REF-1:0] ref_valid,
    input logic             auto_mode,
    input logic             revert_en,
    input logic [IDX_W-1:0] man_sel,
    input logic [IDX_W-1:0] sel_idx,
    input logic             holdover,
    input logic             switch_pulse
);
    logic             past_ok;
    logic [N_REF-1:0] p_valid;
    logic             p_auto;
    logic             p_rev;
    logic [IDX_W-1:0] p_man;
    logic [IDX_W-1:0] p_sel;
    logic             p_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
        p_valid <= ref_valid;
        p_auto  <= auto_mode;
        p_rev   <= revert_en;
        p_man   <= man_sel;
        p_sel   <= sel_idx;
        p_hold  <= holdover;
    end

    // R4: holdover in automatic mode only when nothing was valid
    assert_auto_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_auto && holdover) |-> (p_valid == '0));

    // R3: a tracked reference was valid on the deciding edge
    assert_sel_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !holdover) |-> p_valid[sel_idx]);

    // R6: non-revertive keeps a still-valid selection
    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_auto && !p_rev && !p_hold && p_valid[p_sel]) |-> (!holdover && sel_idx == p_sel));

    // R7: manual mode follows the pin
    assert_manual_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !p_auto && !holdover) |-> (sel_idx == p_man));

    // R8: manual mode with an invalid choice requests holdover
    assert_manual_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !p_auto && !p_valid[p_man]) |-> holdover);

    // R9: pulse marks exactly the cycles where selection or holdover moved
    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (switch_pulse == ((sel_idx != p_sel) || (holdover != p_hold))));

    // R11: holdover keeps the last index
    assert_hold_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && p_hold && holdover) |-> (sel_idx == p_sel));
endmodule

bind ref_clk_selector rcs_checker i_rcs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_valid    (ref_valid),
    .auto_mode    (auto_mode),
    .revert_en    (revert_en),
    .man_sel      (man_sel),
    .sel_idx      (sel_idx),
    .holdover     (holdover),
    .switch_pulse (switch_pulse)
);

// File: tb/test_ref_clk_selector.sv
`timescale 1ns/1ps
module test_ref_clk_selector;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ref_valid;
    logic       auto_mode;
    logic       revert_en;
    logic [0:0] prio_sel;
    logic [0:0] man_sel;
    logic [0:0] sel_idx;
    logic       holdover;
    logic       switch_pulse;
    logic       status_chg;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ref_clk_selector i_ref_clk_selector (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .auto_mode    (auto_mode),
        .revert_en    (revert_en),
        .prio_sel     (prio_sel),
        .man_sel      (man_sel),
        .sel_idx      (sel_idx),
        .holdover     (holdover),
        .switch_pulse (switch_pulse),
        .status_chg   (status_chg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] v, input logic am, input logic rv,
                         input logic pr, input logic ms);
        @(negedge clk);
        ref_valid = v; auto_mode = am; revert_en = rv; prio_sel = pr; man_sel = ms;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ref_valid = 2'b00; auto_mode = 1'b1; revert_en = 1'b0;
        prio_sel = 1'b0; man_sel = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "holdover", holdover, 1);
        chk("R1", "sel_idx", sel_idx, 0);
        chk("R1", "switch_pulse", switch_pulse, 0);
        chk("R1", "status_chg", status_chg, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_powerup();
        apply(2'b11, 1, 0, 0, 0);
        chk("R2", "sel_idx", sel_idx, 0);
        chk("R2", "holdover", holdover, 0);
        chk("R9", "switch_pulse on exit", switch_pulse, 1);
        chk("R10", "status_chg", status_chg, 1);
        apply(2'b11, 1, 0, 0, 0);
        chk("R9", "switch_pulse one cycle", switch_pulse, 0);
        chk("R10", "status_chg one cycle", status_chg, 0);
    endtask

    task automatic t_failover();
        apply(2'b10, 1, 0, 0, 0);
        chk("R3", "sel_idx", sel_idx, 1);
        chk("R3", "holdover", holdover, 0);
        chk("R9", "switch_pulse", switch_pulse, 1);
    endtask

    task automatic t_nonrevert();
        apply(2'b11, 1, 0, 0, 0);
        chk("R6", "sel_idx", sel_idx, 1);
        chk("R9", "no switch_pulse", switch_pulse, 0);
        chk("R10", "status_chg", status_chg, 1);
        apply(2'b11, 1, 0, 0, 0);
        chk("R6", "sel_idx held", sel_idx, 1);
    endtask

    task automatic t_revert();
        apply(2'b11, 1, 1, 0, 0);
        chk("R5", "sel_idx", sel_idx, 0);
        chk("R9", "switch_pulse", switch_pulse, 1);
    endtask

    task automatic t_holdover();
        apply(2'b00, 1, 1, 0, 0);
        chk("R4", "holdover", holdover, 1);
        chk("R11", "sel_idx kept", sel_idx, 0);
        chk("R9", "switch_pulse on entry", switch_pulse, 1);
        apply(2'b00, 1, 1, 0, 0);
        chk("R4", "holdover stays", holdover, 1);
        chk("R9", "switch_pulse low", switch_pulse, 0);
    endtask

    task automatic t_prio_exit();
        apply(2'b11, 1, 0, 1, 0);
        chk("R2", "prio 1 sel_idx", sel_idx, 1);
        chk("R2", "holdover", holdover, 0);
        chk("R9", "switch_pulse", switch_pulse, 1);
    endtask

    task automatic t_manual();
        apply(2'b11, 0, 0, 1, 0);
        chk("R7", "man 0 sel_idx", sel_idx, 0);
        chk("R7", "holdover", holdover, 0);
        apply(2'b11, 0, 0, 1, 1);
        chk("R7", "man 1 sel_idx", sel_idx, 1);
    endtask

    task automatic t_manual_invalid();
        apply(2'b01, 0, 0, 0, 1);
        chk("R8", "holdover", holdover, 1);
        chk("R8", "no switch to ref0", sel_idx, 1);
        chk("R9", "switch_pulse on entry", switch_pulse, 1);
        apply(2'b01, 0, 0, 0, 1);
        chk("R8", "holdover stays", holdover, 1);
        chk("R11", "sel_idx kept", sel_idx, 1);
        apply(2'b11, 0, 0, 0, 1);
        chk("R7", "return sel_idx", sel_idx, 1);
        chk("R9", "switch_pulse on exit", switch_pulse, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_powerup();
                t_failover();
                t_nonrevert();
                t_revert();
                t_holdover();
                t_prio_exit();
                t_manual();
                t_manual_invalid();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_errors++;
                    $display("FAIL watchdog: actual=hung expected=done");
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule